// File: doc/BRIEF.md
# Descriptor Ring Position Counter

This block keeps track of where a network DMA engine stands in a circular ring of buffer descriptors. One instance serves the receive ring and a second serves the transmit ring. Each instance holds two 16-bit registers. The ring length register holds the length as a negative two's complement count. The position counter climbs from the first descriptor toward zero, and zero marks the last descriptor of the ring.

Software reaches both registers through a 32-bit host port. That port opens only while the controller is stopped or suspended. The initialization sequence loads the length and places the counter on the first descriptor. After that, each advance pulse from the controller steps the counter and wraps it at the end of the ring. The block derives a zero-based descriptor index and a last-descriptor flag, which the fetch logic uses to form descriptor addresses.

Top module: `drp_ring_pos`

## Requirements
- R1: While `ctl_stop` or `ctl_spnd` is high, a host write stores `host_wdata[15:0]` into the selected register. `host_sel` 0 selects the position counter and 1 selects the ring length. A host read in the same state returns the selected register in bits 15:0.
- R2: While both `ctl_stop` and `ctl_spnd` are low, host writes change neither register and `host_rdata` reads as all zeros.
- R3: Bits 31:16 of a host write are dropped, and bits 31:16 of `host_rdata` are always zero.
- R4: An `init_load` pulse stores the two's complement of `init_len` into the length register and sets the counter to that value plus one (the first descriptor), whatever the state of `ctl_stop` and `ctl_spnd`.
- R5: An advance pulse with a nonzero counter and a nonzero length register increments the counter by one.
- R6: An advance pulse with the counter at zero reloads the counter with the length register value plus one, which wraps the ring to its first descriptor.
- R7: `last_desc` is high exactly when the counter is zero.
- R8: `desc_idx` equals counter minus effective length minus one, modulo 2^16. This gives 0 on the first descriptor and N-1 on the last descriptor of an N-entry ring (1 <= N <= 65535).
- R9: A length register of zero is illegal and is treated as a length of 1 (effective value 0xFFFF). An advance pulse in that state leaves the counter at zero, and an `init_load` with `init_len` 0 also sets the counter to zero.
- R10: `rst_n` changes neither the counter nor the length register.
- R11: Within one cycle, `init_load` takes priority over a host write, and a host write to the counter takes priority over an advance pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; ring state is kept across it |
| ctl_stop | input | 1 | Controller stopped; opens host access |
| ctl_spnd | input | 1 | Controller suspended; opens host access |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 counter, 1 length |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| init_load | input | 1 | Load pulse from the initialization sequence |
| init_len | input | 16 | Ring length N from the initialization block |
| adv | input | 1 | Step to the next descriptor |
| desc_idx | output | 16 | Zero-based index of the current descriptor |
| last_desc | output | 1 | Current descriptor is the last in the ring |

## Verification
The bench builds the block with its default widths: a 16-bit counter, a 32-bit host bus, and reads that return zero while access is closed. The full 16-bit arithmetic therefore applies, so the directed cases reach both ends of the legal range. A 65535-entry ring is walked across its last-to-first wrap, and a 1-entry ring sits permanently on zero. The random phase programs rings of one to seven entries, so a few thousand cycles cover many wraps and the illegal zero length. These random cycles also mix locked and unlocked host traffic with advance pulses and initialization loads in the same cycle.

// File: rtl/drp_pkg.sv
package drp_pkg;

   // Host register select encoding
   typedef enum logic {
      SEL_CTR = 1'b0,
      SEL_LEN = 1'b1
   } drp_sel_e;

   // Largest counter width the library supports
   localparam int unsigned DRP_MAX_W = 32;

endpackage

// File: rtl/drp_host_port.sv
module drp_host_port
   import drp_pkg::*;
#(
   parameter int unsigned CNT_W            = 16,
   parameter int unsigned BUS_W            = 32,
   parameter bit          LOCKED_READ_ZERO = 1'b1
) (
   input  logic             host_wr,
   input  logic             host_sel,
   input  logic [BUS_W-1:0] host_wdata,
   input  logic             ctl_stop,
   input  logic             ctl_spnd,
   input  logic [CNT_W-1:0] ctr_q,
   input  logic [CNT_W-1:0] len_q,
   output logic             ctr_wr,
   output logic             len_wr,
   output logic [CNT_W-1:0] wr_val,
   output logic [BUS_W-1:0] host_rdata
);

   localparam int unsigned HI_W = BUS_W - CNT_W;

   if (BUS_W < CNT_W) begin : g_bad_bus
      $error("drp_host_port: BUS_W must be at least CNT_W");
   end

   drp_sel_e   sel;
   logic       unlocked;
   logic [CNT_W-1:0] sel_val;
   logic       unused_hi;

   assign sel      = drp_sel_e'(host_sel);
   assign unlocked = ctl_stop | ctl_spnd;
   assign wr_val   = host_wdata[CNT_W-1:0];
   assign ctr_wr   = host_wr & unlocked & (sel == SEL_CTR);
   assign len_wr   = host_wr & unlocked & (sel == SEL_LEN);
   assign sel_val  = (sel == SEL_LEN) ? len_q : ctr_q;
   assign unused_hi = ^host_wdata;

   if (LOCKED_READ_ZERO) begin : g_rd_gated
      assign host_rdata = unlocked ? BUS_W'(sel_val) : '0;
   end else begin : g_rd_open
      assign host_rdata = BUS_W'(sel_val);
   end

   // R3: upper read bits never carry data
   always_comb begin
      if (HI_W > 0) begin
         a_r3_upper_zero : assert ((host_rdata >> CNT_W) == '0);
      end
   end

endmodule

// File: rtl/drp_len_reg.sv
module drp_len_reg #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_load,
   input  logic [CNT_W-1:0] init_len,
   input  logic             len_wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] len_q,
   output logic [CNT_W-1:0] len_eff,
   output logic             len_zero
);

   localparam logic [CNT_W-1:0] LEN_ONE_NEG = '1;

   logic [CNT_W-1:0] len_d;

   always_comb begin
      len_d = len_q;
      if (init_load) begin
         len_d = CNT_W'(0) - init_len;
      end else if (len_wr) begin
         len_d = wr_val;
      end
   end

   // No reset: ring state survives every reset source
   always_ff @(posedge clk) begin
      len_q <= len_d;
   end

   assign len_zero = (len_q == '0);
   assign len_eff  = len_zero ? LEN_ONE_NEG : len_q;

   // R4: initialization stores the negated length
   a_r4_init_len : assert property (@(posedge clk) disable iff (!rst_n)
      init_load |=> (len_q == CNT_W'(CNT_W'(0) - $past(init_len))));

   // R1: an open host write lands in the length register
   a_r1_len_write : assert property (@(posedge clk) disable iff (!rst_n)
      (len_wr && !init_load) |=> (len_q == $past(wr_val)));

endmodule

// File: rtl/drp_pos_ctr.sv
module drp_pos_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_load,
   input  logic [CNT_W-1:0] init_first,
   input  logic             ctr_wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             adv,
   input  logic [CNT_W-1:0] len_q,
   input  logic             len_zero,
   output logic [CNT_W-1:0] ctr_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] ctr_d;
   logic             at_last;

   assign at_last = (ctr_q == '0);

   always_comb begin
      ctr_d = ctr_q;
      if (init_load) begin
         ctr_d = init_first;
      end else if (ctr_wr) begin
         ctr_d = wr_val;
      end else if (adv) begin
         if (len_zero) begin
            ctr_d = '0;
         end else if (at_last) begin
            ctr_d = len_q + ONE;
         end else begin
            ctr_d = ctr_q + ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      ctr_q <= ctr_d;
   end

   // R5: step toward zero
   a_r5_step : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !init_load && !ctr_wr && !len_zero && ctr_q != '0)
      |=> (ctr_q == $past(ctr_q) + ONE));

   // R6: wrap from last descriptor to first
   a_r6_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !init_load && !ctr_wr && !len_zero && ctr_q == '0)
      |=> (ctr_q == $past(len_q) + ONE));

   // R9: illegal zero length pins the counter at zero
   a_r9_zero_len : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !init_load && !ctr_wr && len_zero) |=> (ctr_q == '0));

   // R11: host write beats advance
   a_r11_wr_first : assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_wr && !init_load) |=> (ctr_q == $past(wr_val)));

endmodule

// File: rtl/drp_ring_pos.sv
module drp_ring_pos #(
   parameter int unsigned CNT_W            = 16,
   parameter int unsigned BUS_W            = 32,
   parameter bit          LOCKED_READ_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_stop,
   input  logic             ctl_spnd,
   input  logic             host_wr,
   input  logic             host_sel,
   input  logic [BUS_W-1:0] host_wdata,
   output logic [BUS_W-1:0] host_rdata,
   input  logic             init_load,
   input  logic [CNT_W-1:0] init_len,
   input  logic             adv,
   output logic [CNT_W-1:0] desc_idx,
   output logic             last_desc
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > drp_pkg::DRP_MAX_W) begin : g_bad_cnt
      $error("drp_ring_pos: CNT_W out of range");
   end

   logic [CNT_W-1:0] ctr_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] len_eff;
   logic             len_zero;
   logic             ctr_wr;
   logic             len_wr;
   logic [CNT_W-1:0] wr_val;
   logic [CNT_W-1:0] init_first;

   // First descriptor sits one above the negated length; zero length pins to 0
   assign init_first = (init_len == '0) ? '0 : (ONE - init_len);

   drp_host_port #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .LOCKED_READ_ZERO(LOCKED_READ_ZERO)
   ) u_port (
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .ctl_stop(ctl_stop), .ctl_spnd(ctl_spnd),
      .ctr_q(ctr_q), .len_q(len_q),
      .ctr_wr(ctr_wr), .len_wr(len_wr), .wr_val(wr_val),
      .host_rdata(host_rdata)
   );

   drp_len_reg #(.CNT_W(CNT_W)) u_len (
      .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_len(init_len),
      .len_wr(len_wr), .wr_val(wr_val),
      .len_q(len_q), .len_eff(len_eff), .len_zero(len_zero)
   );

   drp_pos_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_first(init_first),
      .ctr_wr(ctr_wr), .wr_val(wr_val), .adv(adv),
      .len_q(len_q), .len_zero(len_zero), .ctr_q(ctr_q)
   );

   assign last_desc = (ctr_q == '0);
   assign desc_idx  = ctr_q - len_eff - ONE;

   // R2: closed host port leaves the length untouched
   a_r2_locked_len : assert property (@(posedge clk) disable iff (!rst_n)
      (!init_load && !ctl_stop && !ctl_spnd) |=> $stable(len_q));

   // R2: closed host port reads as zero
   a_r2_locked_read : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_stop && !ctl_spnd) |-> (host_rdata == '0));

endmodule

// File: tb/tb_drp_ring_pos.sv
`timescale 1ns/1ps
module tb_drp_ring_pos;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_stop = 1'b0, ctl_spnd = 1'b0;
   logic        host_wr = 1'b0, host_sel = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        init_load = 1'b0;
   logic [15:0] init_len = '0;
   logic        adv = 1'b0;
   logic [15:0] desc_idx;
   logic        last_desc;

   int unsigned n_vec = 0, n_bad = 0;
   bit          done = 1'b0;
   logic [15:0] m_len = '0, m_ctr = '0;

   always #2.5 clk = ~clk;

   drp_ring_pos dut (
      .clk(clk), .rst_n(rst_n), .ctl_stop(ctl_stop), .ctl_spnd(ctl_spnd),
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .init_load(init_load), .init_len(init_len),
      .adv(adv), .desc_idx(desc_idx), .last_desc(last_desc)
   );

   function automatic logic [15:0] f_eff(logic [15:0] l);
      return (l == 16'h0) ? 16'hFFFF : l;
   endfunction

   function automatic logic [15:0] f_idx(logic [15:0] c, logic [15:0] l);
      return c - f_eff(l) - 16'd1;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // One clock of stimulus, called at a falling edge; returns at the next one
   task automatic cyc(bit stop, bit spnd, bit wr, bit sel, logic [31:0] wd,
                      bit ld, logic [15:0] il, bit a);
      logic [15:0] nl, nc;
      ctl_stop = stop; ctl_spnd = spnd; host_wr = wr; host_sel = sel;
      host_wdata = wd; init_load = ld; init_len = il; adv = a;
      #1;
      chk((stop | spnd) ? "R1 read" : "R2 read", host_rdata,
          (stop | spnd) ? {16'h0, (sel ? m_len : m_ctr)} : 32'h0);
      nl = m_len; nc = m_ctr;
      if (ld) begin
         nl = 16'h0 - il;
         nc = (il == 16'h0) ? 16'h0 : 16'h1 - il;
      end else begin
         if (wr && (stop || spnd) && sel) nl = wd[15:0];
         if (wr && (stop || spnd) && !sel) nc = wd[15:0];
         else if (a) begin
            if (m_len == 16'h0) nc = 16'h0;
            else if (m_ctr == 16'h0) nc = m_len + 16'd1;
            else nc = m_ctr + 16'd1;
         end
      end
      @(posedge clk);
      m_len = nl; m_ctr = nc;
      @(negedge clk);
      host_wr = 1'b0; init_load = 1'b0; adv = 1'b0;
      chk("R8 index", {16'h0, desc_idx}, {16'h0, f_idx(m_ctr, m_len)});
      chk("R7 last", {31'h0, last_desc}, {31'h0, (m_ctr == 16'h0)});
   endtask

   task automatic rd(bit sel, output logic [31:0] v);
      ctl_stop = 1'b1; host_wr = 1'b0; host_sel = sel;
      #1; v = host_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: ring of length 1
      cyc(0, 0, 0, 0, 0, 1, 16'd1, 0);
      rd(1, v); chk("R4 len", v, 32'h0000FFFF);
      rd(0, v); chk("R4 first", v, 32'h0);
      // R6: one-entry ring wraps onto itself
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      rd(0, v); chk("R6 wrap len1", v, 32'h0);

      // R4: ring of 65535
      cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 0);
      rd(0, v); chk("R4 first max", v, 32'h00000002);
      chk("R8 first idx", {16'h0, desc_idx}, 32'h0);
      cyc(1, 0, 1, 0, 32'h0000FFFF, 0, 0, 0);
      // R5: step onto the last descriptor
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      chk("R5 step", {16'h0, desc_idx}, 32'h0000FFFE);
      chk("R7 last max", {31'h0, last_desc}, 32'h1);
      // R6: wrap to first
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      rd(0, v); chk("R6 wrap max", v, 32'h00000002);

      // R2: locked write ignored
      cyc(0, 0, 1, 1, 32'h00001234, 0, 0, 0);
      rd(1, v); chk("R2 locked write", v, 32'h00000001);
      // R3: upper write bits dropped
      cyc(0, 1, 1, 1, 32'hABCD0003, 0, 0, 0);
      rd(1, v); chk("R3 upper dropped", v, 32'h00000003);

      // R9: zero length pins counter
      cyc(1, 0, 1, 0, 32'h00000005, 0, 0, 0);
      cyc(1, 0, 1, 1, 32'h0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      rd(0, v); chk("R9 clamp", v, 32'h0);
      chk("R9 idx", {16'h0, desc_idx}, 32'h0);

      // R11: init beats host write; host write beats advance
      cyc(1, 0, 1, 1, 32'h00000009, 1, 16'd4, 0);
      rd(1, v); chk("R11 init wins", v, 32'h0000FFFC);
      cyc(1, 0, 1, 0, 32'h0000FFFE, 0, 0, 1);
      rd(0, v); chk("R11 write wins", v, 32'h0000FFFE);

      // R10: reset leaves ring state alone
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rd(0, v); chk("R10 ctr kept", v, {16'h0, m_ctr});
      rd(1, v); chk("R10 len kept", v, {16'h0, m_len});
      rst_n = 1'b1;
      @(negedge clk);

      // Random phase, small rings
      for (int i = 0; i < 4000; i++) begin
         bit s, p, w, sl, l, a;
         logic [31:0] wd;
         logic [15:0] il;
         s  = ($urandom % 4) == 0;
         p  = ($urandom % 4) == 0;
         w  = ($urandom % 3) == 0;
         sl = $urandom % 2;
         l  = ($urandom % 40) == 0;
         a  = $urandom % 2;
         il = 16'($urandom % 8);
         wd = $urandom;
         if (sl) wd[15:0] = (($urandom % 8) == 0) ? 16'h0 : 16'h0 - 16'(1 + $urandom % 7);
         else    wd[15:0] = 16'h0 - 16'($urandom % 7);
         cyc(s, p, w, sl, wd, l, il, a);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule